// File: doc/BRIEF.md
# Collision Jam and Retry Controller

This block drives the transmit side of a half-duplex 10 Mb/s MAC through one frame, from the start request to the final status. It follows the bit timing of each attempt through a bit-time tick. It also tells the serializer what to send through a select code: preamble with the start-of-frame delimiter, frame data, or jam. A collision input stops the attempt. Where the collision falls decides how the attempt ends. A collision during the preamble lets the preamble run to its end and then adds the jam. A collision during the data cuts the frame off and starts the jam at once.

After an in-slot collision the block asks an external timer to wait a number of slot times. It draws that number from an LFSR using truncated binary exponential backoff. When the timer reports back, the block starts the next attempt. It reports success, a retry-limit failure or a late collision. Two retry flags show whether one retry or several retries were needed.

Top module: `jam_retry_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls, `sel` is 0 (idle) and `backoff_req`, `done`, `tx_ok`, `retry_fail`, `late_col`, `one_retry` and `multi_retry` are all 0.
- R2: A `tx_req` seen while idle latches `frame_len` (at least 1). It clears all status flags, sets the attempt count to 1 and starts an attempt. An attempt shows `sel`=1 for 64 bit ticks and then `sel`=2 for `frame_len` ticks. If no collision occurs, the tick that ends the last data bit returns `sel` to 0 and pulses `done` for one cycle with `tx_ok`=1.
- R3: A collision seen at any cycle while `sel`=1 does not shorten the preamble. `sel` stays 1 until the 64th tick and then becomes 3 (jam) instead of 2.
- R4: A collision while `sel`=2 makes `sel` 3 in the very next cycle. It does this even when the collision comes in the same cycle as the tick that would end the frame.
- R5: The jam (all-zero bits, `sel`=3) lasts exactly 32 bit ticks. A collision input while jamming, idle or waiting for backoff has no effect on any output.
- R6: After the jam of an in-slot collision on attempt n (n below 16), `backoff_req` rises. `backoff_slots` holds a value from 0 to 2^min(n,10)−1, and both stay until `backoff_done`. The next cycle starts a new attempt with a full preamble.
- R7: `one_retry` is set when the first retry is scheduled. `multi_retry` replaces it when a second or later retry is scheduled. The two are never set together.
- R8: If attempt 16 collides in the slot, the end of its jam pulses `done` with `retry_fail`=1 and `backoff_req` never rises. The frame is dropped.
- R9: A collision after 512 or more data bits is late. Collision after 511 data bits is still in the slot. A late collision is jammed and then ends the frame with `done` and `late_col`=1, with no retry.
- R10: `tx_req` while an attempt, jam or backoff is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| col_in | input | 1 | Collision indication |
| tx_req | input | 1 | Start a new frame |
| frame_len | input | LEN_W | Data bits in the frame, sampled at start |
| backoff_done | input | 1 | Backoff timer has expired |
| sel | output | 2 | 0 idle, 1 preamble/SFD, 2 data, 3 jam |
| backoff_req | output | 1 | Backoff delay requested |
| backoff_slots | output | BO_CAP | Number of 512-bit slots to wait |
| done | output | 1 | One-cycle end-of-frame pulse |
| tx_ok | output | 1 | Frame sent without error |
| retry_fail | output | 1 | Retry limit reached, frame dropped |
| late_col | output | 1 | Late collision ended the frame |
| one_retry | output | 1 | Exactly one retry so far |
| multi_retry | output | 1 | More than one retry so far |

## Verification
Collision and bit tick can arrive in the same cycle. Where that happens changes the outcome. The bench times collisions to fall exactly on the tick that ends the preamble, and on the tick that would end the last data bit. It also places them on either side of the 512-bit slot boundary. A bench model decides each case by the priority rules: the preamble always completes, and a collision in data overrides the final tick. That model is compared with the outputs on every clock. End-of-frame checks also compare the final status against fixed expected values.

// File: rtl/jam_retry_pkg.sv
package jam_retry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_DATA = 3'd2,
    ST_JAM  = 3'd3,
    ST_WAIT = 3'd4
  } jr_state_t;

  localparam logic [1:0] SEL_IDLE = 2'd0;
  localparam logic [1:0] SEL_PRE  = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_JAM  = 2'd3;
endpackage

// File: rtl/jr_lfsr.sv
module jr_lfsr #(
  parameter int LFSR_W = 16,
  parameter int OUT_W  = 10,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd
);
  logic [LFSR_W-1:0] q;

  // Galois form, advances every clock so the draw depends on timing too
  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else if (q[0]) q <= (q >> 1) ^ TAPS;
    else q <= q >> 1;
  end

  assign rnd = q[OUT_W-1:0];
endmodule

// File: rtl/jr_attempts.sv
module jr_attempts #(
  parameter int MAX_ATT = 16,
  parameter int BO_CAP  = 10,
  localparam int ATT_W  = $clog2(MAX_ATT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              inc,
  output logic [ATT_W-1:0]  cnt,
  output logic [BO_CAP-1:0] mask,
  output logic              last,
  output logic              one,
  output logic              multi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      one   <= 1'b0;
      multi <= 1'b0;
    end else if (clr) begin
      cnt   <= ATT_W'(1);
      one   <= 1'b0;
      multi <= 1'b0;
    end else if (inc) begin
      cnt   <= cnt + 1'b1;
      one   <= (cnt == ATT_W'(1));
      multi <= (cnt >= ATT_W'(2));
    end
  end

  // window of 2^min(cnt,BO_CAP) slots: low min(cnt,BO_CAP) bits open
  always_comb begin
    for (int i = 0; i < BO_CAP; i++) mask[i] = (i < int'(cnt));
  end

  assign last = (cnt == ATT_W'(MAX_ATT));
endmodule

// File: rtl/jam_retry_ctrl.sv
module jam_retry_ctrl
  import jam_retry_pkg::*;
#(
  parameter int PRE_BITS  = 64,
  parameter int JAM_BITS  = 32,
  parameter int SLOT_BITS = 512,
  parameter int MAX_ATT   = 16,
  parameter int BO_CAP    = 10,
  parameter int LEN_W     = 14,
  parameter int LFSR_W    = 16,
  localparam int PRE_W    = $clog2(PRE_BITS),
  localparam int JAM_W    = $clog2(JAM_BITS),
  localparam int ATT_W    = $clog2(MAX_ATT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic              col_in,
  input  logic              tx_req,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              backoff_done,
  output logic [1:0]        sel,
  output logic              backoff_req,
  output logic [BO_CAP-1:0] backoff_slots,
  output logic              done,
  output logic              tx_ok,
  output logic              retry_fail,
  output logic              late_col,
  output logic              one_retry,
  output logic              multi_retry
);
  jr_state_t         state;
  logic [PRE_W-1:0]  pre_cnt;
  logic [LEN_W-1:0]  dat_cnt;
  logic [LEN_W-1:0]  len_q;
  logic [JAM_W-1:0]  jam_cnt;
  logic              col_pend;
  logic              late_q;
  logic [ATT_W-1:0]  att_cnt;
  logic [BO_CAP-1:0] att_mask;
  logic              att_last;
  logic [BO_CAP-1:0] rnd;
  logic              accept;
  logic              jam_end;
  logic              sched;

  assign accept  = (state == ST_IDLE) && tx_req;
  assign jam_end = (state == ST_JAM) && bit_tick && (jam_cnt == JAM_W'(JAM_BITS - 1));
  assign sched   = jam_end && !late_q && !att_last;

  jr_lfsr #(.LFSR_W(LFSR_W), .OUT_W(BO_CAP)) u_lfsr (
    .clk(clk), .rst(rst), .rnd(rnd)
  );

  jr_attempts #(.MAX_ATT(MAX_ATT), .BO_CAP(BO_CAP)) u_att (
    .clk(clk), .rst(rst), .clr(accept), .inc(sched),
    .cnt(att_cnt), .mask(att_mask), .last(att_last),
    .one(one_retry), .multi(multi_retry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      pre_cnt       <= '0;
      dat_cnt       <= '0;
      len_q         <= '0;
      jam_cnt       <= '0;
      col_pend      <= 1'b0;
      late_q        <= 1'b0;
      backoff_slots <= '0;
      done          <= 1'b0;
      tx_ok         <= 1'b0;
      retry_fail    <= 1'b0;
      late_col      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (tx_req) begin
          state      <= ST_PRE;
          pre_cnt    <= '0;
          col_pend   <= 1'b0;
          len_q      <= frame_len;
          tx_ok      <= 1'b0;
          retry_fail <= 1'b0;
          late_col   <= 1'b0;
        end
        ST_PRE: begin
          if (col_in) col_pend <= 1'b1;
          if (bit_tick) begin
            if (pre_cnt == PRE_W'(PRE_BITS - 1)) begin
              pre_cnt <= '0;
              if (col_pend || col_in) begin
                state   <= ST_JAM;
                jam_cnt <= '0;
                late_q  <= 1'b0;
              end else begin
                state   <= ST_DATA;
                dat_cnt <= '0;
              end
            end else begin
              pre_cnt <= pre_cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (col_in) begin
            state   <= ST_JAM;
            jam_cnt <= '0;
            late_q  <= (dat_cnt >= LEN_W'(SLOT_BITS));
          end else if (bit_tick) begin
            if (dat_cnt == len_q - 1'b1) begin
              state <= ST_IDLE;
              done  <= 1'b1;
              tx_ok <= 1'b1;
            end else begin
              dat_cnt <= dat_cnt + 1'b1;
            end
          end
        end
        ST_JAM: if (bit_tick) begin
          if (jam_cnt == JAM_W'(JAM_BITS - 1)) begin
            if (late_q) begin
              state    <= ST_IDLE;
              done     <= 1'b1;
              late_col <= 1'b1;
            end else if (att_last) begin
              state      <= ST_IDLE;
              done       <= 1'b1;
              retry_fail <= 1'b1;
            end else begin
              state         <= ST_WAIT;
              backoff_slots <= rnd & att_mask;
            end
          end else begin
            jam_cnt <= jam_cnt + 1'b1;
          end
        end
        ST_WAIT: if (backoff_done) begin
          state    <= ST_PRE;
          pre_cnt  <= '0;
          col_pend <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_PRE:  sel = SEL_PRE;
      ST_DATA: sel = SEL_DATA;
      ST_JAM:  sel = SEL_JAM;
      default: sel = SEL_IDLE;
    endcase
  end

  assign backoff_req = (state == ST_WAIT);
endmodule

// File: rtl/jam_retry_chk.sv
module jam_retry_chk #(
  parameter int BO_CAP  = 10,
  parameter int MAX_ATT = 16,
  parameter int ATT_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_tick,
  input logic              col_in,
  input logic [1:0]        sel,
  input logic              backoff_req,
  input logic [BO_CAP-1:0] backoff_slots,
  input logic              done,
  input logic              tx_ok,
  input logic              retry_fail,
  input logic              late_col,
  input logic              one_retry,
  input logic              multi_retry,
  input logic [ATT_W-1:0]  att
);
  logic slots_over;
  always_comb begin
    slots_over = 1'b0;
    for (int i = 0; i < BO_CAP; i++)
      if (i >= int'(att) - 1 && backoff_slots[i]) slots_over = 1'b1;
  end

  // R6
  slots_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    backoff_req |-> !slots_over);

  // R7
  retry_flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(one_retry && multi_retry));

  // R4
  data_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'd2 && col_in) |=> (sel == 2'd3));

  // R5
  jam_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'd3 && !bit_tick) |=> (sel == 2'd3));

  // R8
  fail_at_limit_chk: assert property (@(posedge clk) disable iff (rst)
    retry_fail |-> (att == ATT_W'(MAX_ATT)));

  // R2
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $onehot({tx_ok, retry_fail, late_col}));
endmodule

bind jam_retry_ctrl jam_retry_chk #(.BO_CAP(BO_CAP), .MAX_ATT(MAX_ATT), .ATT_W(ATT_W)) u_chk (
  .clk(clk), .rst(rst), .bit_tick(bit_tick), .col_in(col_in), .sel(sel),
  .backoff_req(backoff_req), .backoff_slots(backoff_slots), .done(done),
  .tx_ok(tx_ok), .retry_fail(retry_fail), .late_col(late_col),
  .one_retry(one_retry), .multi_retry(multi_retry), .att(att_cnt)
);

// File: tb/sim_jam_retry_ctrl.sv
`timescale 1ns/1ps
module sim_jam_retry_ctrl;
  logic clk = 0;
  logic rst = 1;
  logic bit_tick = 0;
  logic col_sched = 0;
  logic col_extra = 0;
  logic col_in;
  logic tx_req = 0;
  logic [13:0] frame_len = 14'd8;
  logic backoff_done = 0;
  logic [1:0] sel;
  logic backoff_req;
  logic [9:0] backoff_slots;
  logic done, tx_ok, retry_fail, late_col, one_retry, multi_retry;

  assign col_in = col_sched | col_extra;
  always #5 clk = ~clk;

  jam_retry_ctrl u0 (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .col_in(col_in), .tx_req(tx_req),
    .frame_len(frame_len), .backoff_done(backoff_done), .sel(sel),
    .backoff_req(backoff_req), .backoff_slots(backoff_slots), .done(done),
    .tx_ok(tx_ok), .retry_fail(retry_fail), .late_col(late_col),
    .one_retry(one_retry), .multi_retry(multi_retry)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // behavioural reference: 0 idle,1 preamble,2 data,3 jam,4 backoff wait
  int m_state = 0, m_pre = 0, m_d = 0, m_jam = 0, m_att = 0, m_len = 0;
  bit m_pend = 0, m_lq = 0, m_done = 0, m_ok = 0, m_fail = 0, m_late = 0;
  bit m_one = 0, m_multi = 0;

  always @(posedge clk) begin
    m_done = 0;
    if (rst) begin
      m_state = 0; m_att = 0; m_ok = 0; m_fail = 0; m_late = 0;
      m_one = 0; m_multi = 0; m_pend = 0;
    end else begin
      case (m_state)
        0: if (tx_req) begin
          m_state = 1; m_pre = 0; m_pend = 0; m_att = 1; m_len = int'(frame_len);
          m_ok = 0; m_fail = 0; m_late = 0; m_one = 0; m_multi = 0;
        end
        1: begin
          if (col_in) m_pend = 1;
          if (bit_tick) begin
            if (m_pre == 63) begin
              if (m_pend) begin m_state = 3; m_jam = 0; m_lq = 0; end
              else begin m_state = 2; m_d = 0; end
            end else m_pre++;
          end
        end
        2: begin
          if (col_in) begin m_state = 3; m_jam = 0; m_lq = (m_d >= 512); end
          else if (bit_tick) begin
            if (m_d == m_len - 1) begin m_state = 0; m_done = 1; m_ok = 1; end
            else m_d++;
          end
        end
        3: if (bit_tick) begin
          if (m_jam == 31) begin
            if (m_lq) begin m_state = 0; m_done = 1; m_late = 1; end
            else if (m_att == 16) begin m_state = 0; m_done = 1; m_fail = 1; end
            else begin
              m_state = 4; m_att++;
              m_one = (m_att == 2); m_multi = (m_att > 2);
            end
          end else m_jam++;
        end
        4: if (backoff_done) begin m_state = 1; m_pre = 0; m_pend = 0; end
        default: m_state = 0;
      endcase
    end
  end

  // stimulus driven on the falling edge
  int col_pos [16];
  bit fired = 0;
  bit jam_noise = 0;
  int div = 0;
  int bo_wait = 0;
  int bo_seen = 0;
  bit bo_prev = 0;

  always @(negedge clk) begin
    div = (div + 1) % 2;
    bit_tick = (div == 0);
    if (m_state == 0 || m_state == 4) fired = 0;
    col_sched = 0;
    if (!fired && bit_tick && m_att >= 1 && m_att <= 16) begin
      if ((m_state == 1 && col_pos[m_att-1] == m_pre) ||
          (m_state == 2 && col_pos[m_att-1] == m_d + 64)) begin
        col_sched = 1; fired = 1;
      end
    end
    col_extra = jam_noise && (m_state == 3 || m_state == 4);
    if (m_state == 4) bo_wait++; else bo_wait = 0;
    backoff_done = (bo_wait == 3);
  end

  // per-cycle comparison
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      int k;
      bit bad;
      checks++;
      bad = 0;
      if (sel != ((m_state == 4) ? 2'd0 : 2'(m_state))) begin
        $display("FAIL R3/R4 sel got %0d exp %0d at cycle %0d", sel, (m_state == 4) ? 0 : m_state, cycles); bad = 1; end
      if (backoff_req != (m_state == 4)) begin
        $display("FAIL R6 backoff_req got %0b exp %0b", backoff_req, m_state == 4); bad = 1; end
      if (done != m_done) begin
        $display("FAIL R2 done got %0b exp %0b", done, m_done); bad = 1; end
      if ({tx_ok, retry_fail, late_col} != {m_ok, m_fail, m_late}) begin
        $display("FAIL R8/R9 status got %b exp %b", {tx_ok, retry_fail, late_col}, {m_ok, m_fail, m_late}); bad = 1; end
      if ({one_retry, multi_retry} != {m_one, m_multi}) begin
        $display("FAIL R7 retry flags got %b exp %b", {one_retry, multi_retry}, {m_one, m_multi}); bad = 1; end
      if (backoff_req) begin
        k = (m_att - 1 < 10) ? m_att - 1 : 10;
        if (int'(backoff_slots) >= (1 << k)) begin
          $display("FAIL R6 slots got %0d exp below %0d", backoff_slots, 1 << k); bad = 1; end
      end
      if (bad) errors++;
    end
    if (backoff_req && !bo_prev) bo_seen++;
    bo_prev = backoff_req;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired got %0d cycles exp under 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b exp %0b", tag, got, exp);
    end
  endtask

  task automatic set_cols(input int a0, input int a1, input int a2);
    for (int i = 0; i < 16; i++) col_pos[i] = -1;
    col_pos[0] = a0; col_pos[1] = a1; col_pos[2] = a2;
  endtask

  task automatic run_frame(input int len, input bit poke_busy);
    @(negedge clk);
    frame_len = 14'(len);
    tx_req = 1;
    @(negedge clk);
    tx_req = 0;
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      tx_req = 1;           // R10: must be ignored mid-attempt
      frame_len = 14'd3;
      @(negedge clk);
      tx_req = 0;
    end
    for (int t = 0; t < 40000 && !m_done; t++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) col_pos[i] = -1;
    repeat (4) @(negedge clk);
    chk(sel == 2'd0, 1'b1, "R1 sel idle in reset");
    chk(backoff_req | done | tx_ok | one_retry | multi_retry, 1'b0, "R1 outputs low in reset");
    rst = 0;
    @(negedge clk);
    chk(sel == 2'd0 && !done && !retry_fail && !late_col, 1'b1, "R1 idle after reset");

    // R5: collision while idle is ignored
    col_extra = 1; @(negedge clk); col_extra = 0;
    chk(sel == 2'd0, 1'b1, "R5 idle collision ignored");

    // R2 / R10: clean frame with a stray request mid-way
    run_frame(40, 1);
    chk(done && tx_ok, 1'b1, "R2 clean frame ok");
    chk(one_retry | multi_retry, 1'b0, "R7 no retry flags on clean frame");

    // R3 / R5: preamble collision, noise during jam and wait
    jam_noise = 1;
    set_cols(10, -1, -1);
    run_frame(24, 0);
    jam_noise = 0;
    chk(tx_ok && one_retry && !multi_retry, 1'b1, "R3 R7 single retry");

    // R3 / R4: collision on last preamble tick, then in data
    set_cols(63, 64 + 5, -1);
    run_frame(30, 0);
    chk(tx_ok && multi_retry && !one_retry, 1'b1, "R4 R7 multiple retries");

    // R4: collision on the tick that would end the frame
    set_cols(64 + 39, -1, -1);
    run_frame(40, 0);
    chk(tx_ok && one_retry, 1'b1, "R4 collision beats final tick");

    // R8: every attempt collides
    bo_seen = 0;
    for (int i = 0; i < 16; i++) col_pos[i] = 64 + 3;
    run_frame(20, 0);
    chk(done && retry_fail && !tx_ok, 1'b1, "R8 retry limit");
    checks++;
    if (bo_seen != 15) begin errors++; $display("FAIL R6 backoffs got %0d exp 15", bo_seen); end

    // R9: slot edge at 511 is in-slot, 512 is late
    set_cols(64 + 511, 64 + 512, -1);
    run_frame(600, 0);
    chk(done && late_col && !tx_ok && !retry_fail, 1'b1, "R9 late collision");
    chk(one_retry, 1'b1, "R9 collision at 511 was retried");
    repeat (4) @(negedge clk);
    chk(backoff_req, 1'b0, "R9 no backoff after late");

    // R2: next request clears status
    set_cols(-1, -1, -1);
    run_frame(8, 0);
    chk(tx_ok && !late_col && !one_retry, 1'b1, "R2 flags cleared on new request");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule